// File: doc/BRIEF.md
# Register Window Save/Restore Controller

This block keeps the bookkeeping state of a windowed integer register file: the current window pointer, the number of windows that may still be saved or restored, the number of clean windows, the number of windows owned by another context, and a pair of trap-handler selector fields. When the pipeline issues a window save, a window restore or a flush-all-windows operation, the controller updates the state in one clock. It either allows the destination write of the operand sum or requests a spill, fill or clean-window trap, together with the selector field the trap handler needs.

A single privileged write port lets trap handlers and boot code load any state register directly. A privileged write always wins over an operation offered in the same cycle. The register file itself and the trap vector calculation sit outside this block. The operation and write inputs are plain control strobes with no back-pressure: the controller accepts every strobe in the cycle it is presented, so there is no ready signal and nothing is held.

Top module: `rwin_ctrl`

## Requirements
- R1: After reset, cwp is 0, cansave is NWIN-2, canrestore is 0, cleanwin is NWIN-2, otherwin is 0, both selector fields are 0, and trap_req and rd_we are low.
- R2: A save (op_sel 2'b00) with cansave equal to 0 moves cwp forward by 2 modulo NWIN and raises a spill trap (trap_kind 2'b01). The counters are left unchanged and rd_we stays low.
- R3: A save with cansave nonzero and cleanwin equal to canrestore moves cwp forward by 1 and raises a clean-window trap (trap_kind 2'b11, trap_ws 0). The counters are left unchanged and rd_we stays low.
- R4: Any other save moves cwp forward by 1, lowers cansave by 1, raises canrestore by 1 (saturating at NWIN-1), pulses rd_we and presents a_in+b_in on rd_sum.
- R5: A restore (op_sel 2'b01) always moves cwp back by 1 modulo NWIN, including when it traps.
- R6: A restore with canrestore equal to 0 raises a fill trap (trap_kind 2'b10). Otherwise cansave rises by 1 (saturating at NWIN-1), canrestore falls by 1, rd_we pulses and rd_sum is a_in+b_in.
- R7: A spill or fill trap reports in trap_ws the "other" selector field when otherwin is nonzero, and the "normal" field otherwise.
- R8: A flush (op_sel 2'b10) raises a spill trap when cansave differs from NWIN-2, and otherwise changes nothing. cwp never moves on a flush.
- R9: A privileged write (wr_go, wr_sel 0 cwp, 1 cansave, 2 canrestore, 3 cleanwin, 4 otherwin, 5 selectors with normal in wr_data[WSW-1:0] and other in wr_data[2*WSW-1:WSW]) is visible on the next cycle. An operation presented in the same cycle is dropped, with no trap and no rd_we.
- R10: trap_req and rd_we are single-cycle pulses, and trap_kind and trap_ws read 0 when no trap is signalled. op_sel 2'b11, or no strobe at all, leaves all state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_go | input | 1 | Operation strobe |
| op_sel | input | 2 | Operation code: save, restore, flush, none |
| a_in | input | XW | First operand of the destination sum |
| b_in | input | XW | Second operand of the destination sum |
| wr_go | input | 1 | Privileged write strobe |
| wr_sel | input | 3 | Privileged write target select |
| wr_data | input | WDW | Privileged write value |
| cwp | output | CW | Current window pointer |
| cansave | output | CW | Windows available to save |
| canrestore | output | CW | Windows available to restore |
| cleanwin | output | CW | Clean window count |
| otherwin | output | CW | Windows owned by another context |
| wstate_norm | output | WSW | Normal trap selector field |
| wstate_oth | output | WSW | Other trap selector field |
| rd_we | output | 1 | Destination write pulse |
| rd_sum | output | XW | Operand sum for the destination |
| trap_req | output | 1 | Trap request pulse |
| trap_kind | output | 2 | Trap type: 01 spill, 10 fill, 11 clean window |
| trap_ws | output | WSW | Selector field for the trap handler |

## Verification
The assertions assume that every counter and pointer loaded through the privileged port is below NWIN, so that modulo and saturation results stay in range. They also assume that an operation is judged against the state registered in the cycle it is accepted. The bench uses the default eight-window configuration and loads only in-range values. It sweeps every combination of cansave, canrestore and cleanwin, two otherwin settings and the three operations, and reloads the whole state before each operation so that no case depends on the one before it.

// File: rtl/rwin_pkg.sv
package rwin_pkg;
  typedef enum logic [1:0] {
    OP_SAVE    = 2'b00,
    OP_RESTORE = 2'b01,
    OP_FLUSH   = 2'b10,
    OP_NONE    = 2'b11
  } rw_op_e;

  typedef enum logic [1:0] {
    TK_NONE  = 2'b00,
    TK_SPILL = 2'b01,
    TK_FILL  = 2'b10,
    TK_CLEAN = 2'b11
  } rw_trap_e;

  typedef enum logic [1:0] {
    MV_STAY  = 2'b00,
    MV_FWD1  = 2'b01,
    MV_FWD2  = 2'b10,
    MV_BACK1 = 2'b11
  } rw_move_e;

  typedef enum logic [2:0] {
    SEL_CWP     = 3'd0,
    SEL_CANSAVE = 3'd1,
    SEL_CANREST = 3'd2,
    SEL_CLEAN   = 3'd3,
    SEL_OTHER   = 3'd4,
    SEL_WSTATE  = 3'd5
  } rw_sel_e;
endpackage

// File: rtl/rwin_step.sv
module rwin_step
  import rwin_pkg::*;
#(
  parameter int NWIN = 8,
  localparam int CW = $clog2(NWIN)
) (
  input  logic [CW-1:0] cur,
  input  rw_move_e      move,
  output logic [CW-1:0] nxt
);
  localparam bit POW2 = ((NWIN & (NWIN - 1)) == 0);

  generate
    if (POW2) begin : g_wrap
      always_comb begin
        case (move)
          MV_FWD1:  nxt = cur + CW'(1);
          MV_FWD2:  nxt = cur + CW'(2);
          MV_BACK1: nxt = cur - CW'(1);
          default:  nxt = cur;
        endcase
      end
    end else begin : g_mod
      logic [CW:0] wide;
      always_comb begin
        wide = {1'b0, cur};
        case (move)
          MV_FWD1:  wide = {1'b0, cur} + (CW+1)'(1);
          MV_FWD2:  wide = {1'b0, cur} + (CW+1)'(2);
          MV_BACK1: wide = (cur == '0) ? (CW+1)'(NWIN - 1) : {1'b0, cur} - (CW+1)'(1);
          default:  wide = {1'b0, cur};
        endcase
        if (wide >= (CW+1)'(NWIN)) wide = wide - (CW+1)'(NWIN);
        nxt = wide[CW-1:0];
      end
    end
  endgenerate
endmodule

// File: rtl/rwin_judge.sv
module rwin_judge
  import rwin_pkg::*;
#(
  parameter int NWIN = 8,
  localparam int CW = $clog2(NWIN)
) (
  input  logic          go,
  input  rw_op_e        op,
  input  logic [CW-1:0] cansave,
  input  logic [CW-1:0] canrestore,
  input  logic [CW-1:0] cleanwin,
  output rw_trap_e      kind,
  output rw_move_e      move,
  output logic [CW-1:0] cs_nxt,
  output logic [CW-1:0] cr_nxt,
  output logic          dst_we
);
  localparam logic [CW-1:0] CNT_MAX   = CW'(NWIN - 1);
  localparam logic [CW-1:0] FLUSH_REF = CW'(NWIN - 2);

  always_comb begin
    kind   = TK_NONE;
    move   = MV_STAY;
    cs_nxt = cansave;
    cr_nxt = canrestore;
    dst_we = 1'b0;
    if (go) begin
      case (op)
        OP_SAVE: begin
          if (cansave == '0) begin
            kind = TK_SPILL;
            move = MV_FWD2;
          end else if (cleanwin == canrestore) begin
            kind = TK_CLEAN;
            move = MV_FWD1;
          end else begin
            move   = MV_FWD1;
            cs_nxt = cansave - CW'(1);
            cr_nxt = (canrestore == CNT_MAX) ? CNT_MAX : canrestore + CW'(1);
            dst_we = 1'b1;
          end
        end
        OP_RESTORE: begin
          move = MV_BACK1;
          if (canrestore == '0) begin
            kind = TK_FILL;
          end else begin
            cs_nxt = (cansave == CNT_MAX) ? CNT_MAX : cansave + CW'(1);
            cr_nxt = canrestore - CW'(1);
            dst_we = 1'b1;
          end
        end
        OP_FLUSH: begin
          if (cansave != FLUSH_REF) kind = TK_SPILL;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rwin_ctrl.sv
module rwin_ctrl
  import rwin_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int WSW  = 3,
  parameter int XW   = 16,
  localparam int CW  = $clog2(NWIN),
  localparam int WDW = (2 * WSW > CW) ? 2 * WSW : CW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_go,
  input  logic [1:0]     op_sel,
  input  logic [XW-1:0]  a_in,
  input  logic [XW-1:0]  b_in,
  input  logic           wr_go,
  input  logic [2:0]     wr_sel,
  input  logic [WDW-1:0] wr_data,
  output logic [CW-1:0]  cwp,
  output logic [CW-1:0]  cansave,
  output logic [CW-1:0]  canrestore,
  output logic [CW-1:0]  cleanwin,
  output logic [CW-1:0]  otherwin,
  output logic [WSW-1:0] wstate_norm,
  output logic [WSW-1:0] wstate_oth,
  output logic           rd_we,
  output logic [XW-1:0]  rd_sum,
  output logic           trap_req,
  output logic [1:0]     trap_kind,
  output logic [WSW-1:0] trap_ws
);
  localparam logic [CW-1:0] INIT_FREE = CW'(NWIN - 2);

  logic          go;
  rw_trap_e      kind;
  rw_move_e      mv;
  logic [CW-1:0] cs_n, cr_n, cwp_n;
  logic          we_n;
  logic [WSW-1:0] ws_pick;

  assign go      = op_go && !wr_go;
  assign ws_pick = (otherwin != '0) ? wstate_oth : wstate_norm;

  rwin_judge #(.NWIN(NWIN)) u_judge (
    .go         (go),
    .op         (rw_op_e'(op_sel)),
    .cansave    (cansave),
    .canrestore (canrestore),
    .cleanwin   (cleanwin),
    .kind       (kind),
    .move       (mv),
    .cs_nxt     (cs_n),
    .cr_nxt     (cr_n),
    .dst_we     (we_n)
  );

  rwin_step #(.NWIN(NWIN)) u_step (
    .cur  (cwp),
    .move (mv),
    .nxt  (cwp_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cwp         <= '0;
      cansave     <= INIT_FREE;
      canrestore  <= '0;
      cleanwin    <= INIT_FREE;
      otherwin    <= '0;
      wstate_norm <= '0;
      wstate_oth  <= '0;
      rd_we       <= 1'b0;
      rd_sum      <= '0;
      trap_req    <= 1'b0;
      trap_kind   <= 2'b00;
      trap_ws     <= '0;
    end else begin
      rd_we     <= 1'b0;
      trap_req  <= 1'b0;
      trap_kind <= 2'b00;
      trap_ws   <= '0;
      if (wr_go) begin
        case (rw_sel_e'(wr_sel))
          SEL_CWP:     cwp        <= wr_data[CW-1:0];
          SEL_CANSAVE: cansave    <= wr_data[CW-1:0];
          SEL_CANREST: canrestore <= wr_data[CW-1:0];
          SEL_CLEAN:   cleanwin   <= wr_data[CW-1:0];
          SEL_OTHER:   otherwin   <= wr_data[CW-1:0];
          SEL_WSTATE: begin
            wstate_norm <= wr_data[WSW-1:0];
            wstate_oth  <= wr_data[2*WSW-1:WSW];
          end
          default: ;
        endcase
      end else if (go) begin
        cwp        <= cwp_n;
        cansave    <= cs_n;
        canrestore <= cr_n;
        rd_we      <= we_n;
        trap_req   <= (kind != TK_NONE);
        trap_kind  <= 2'(kind);
        trap_ws    <= (kind == TK_SPILL || kind == TK_FILL) ? ws_pick : '0;
        if (we_n) rd_sum <= a_in + b_in;
      end
    end
  end
endmodule

// File: rtl/rwin_ctrl_chk.sv
module rwin_ctrl_chk #(
  parameter int NWIN = 8,
  parameter int WSW  = 3,
  localparam int CW  = $clog2(NWIN)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           op_go,
  input logic [1:0]     op_sel,
  input logic           wr_go,
  input logic [CW-1:0]  cwp,
  input logic [CW-1:0]  cansave,
  input logic [CW-1:0]  canrestore,
  input logic [CW-1:0]  cleanwin,
  input logic [CW-1:0]  otherwin,
  input logic [WSW-1:0] wstate_oth,
  input logic           rd_we,
  input logic           trap_req,
  input logic [1:0]     trap_kind,
  input logic [WSW-1:0] trap_ws
);
  function automatic logic [CW-1:0] ring(input logic [CW-1:0] c, input int k);
    return CW'((int'(c) + k + NWIN) % NWIN);
  endfunction

  logic acc;
  assign acc = op_go && !wr_go;

  a_r2_spill_jump: assert property (@(posedge clk) disable iff (!rst_n)
    acc && op_sel == 2'b00 && cansave == '0 |=>
      trap_req && trap_kind == 2'b01 && !rd_we && cwp == ring($past(cwp), 2));

  a_r4_save_counts: assert property (@(posedge clk) disable iff (!rst_n)
    acc && op_sel == 2'b00 && cansave != '0 && cleanwin != canrestore |=>
      rd_we && !trap_req && cansave == $past(cansave) - CW'(1) && cwp == ring($past(cwp), 1));

  a_r5_restore_back: assert property (@(posedge clk) disable iff (!rst_n)
    acc && op_sel == 2'b01 |=> cwp == ring($past(cwp), -1));

  a_r7_other_field: assert property (@(posedge clk) disable iff (!rst_n)
    acc && op_sel != 2'b11 && otherwin != '0 |=>
      !trap_req || trap_kind == 2'b11 || trap_ws == $past(wstate_oth));

  a_r8_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    acc && op_sel == 2'b10 && cansave == CW'(NWIN - 2) |=> !trap_req && $stable(cwp));

  a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |=> !trap_req && !rd_we);

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !op_go && !wr_go |=> !trap_req && !rd_we && $stable(cwp) && $stable(cansave) && $stable(canrestore));
endmodule

bind rwin_ctrl rwin_ctrl_chk #(.NWIN(NWIN), .WSW(WSW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_go      (op_go),
  .op_sel     (op_sel),
  .wr_go      (wr_go),
  .cwp        (cwp),
  .cansave    (cansave),
  .canrestore (canrestore),
  .cleanwin   (cleanwin),
  .otherwin   (otherwin),
  .wstate_oth (wstate_oth),
  .rd_we      (rd_we),
  .trap_req   (trap_req),
  .trap_kind  (trap_kind),
  .trap_ws    (trap_ws)
);

// File: tb/rwin_ctrl_test.sv
module rwin_ctrl_test;
  localparam int CLK_PER = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_go = 1'b0;
  logic [1:0]  op_sel = 2'b11;
  logic [15:0] a_in = '0, b_in = '0;
  logic        wr_go = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [5:0]  wr_data = '0;
  logic [2:0]  cwp, cansave, canrestore, cleanwin, otherwin, wstate_norm, wstate_oth, trap_ws;
  logic        rd_we, trap_req;
  logic [15:0] rd_sum;
  logic [1:0]  trap_kind;

  int n_run = 0;
  int n_bad = 0;

  always #(CLK_PER/2) clk = ~clk;

  rwin_ctrl uut (
    .clk(clk), .rst_n(rst_n), .op_go(op_go), .op_sel(op_sel), .a_in(a_in), .b_in(b_in),
    .wr_go(wr_go), .wr_sel(wr_sel), .wr_data(wr_data), .cwp(cwp), .cansave(cansave),
    .canrestore(canrestore), .cleanwin(cleanwin), .otherwin(otherwin),
    .wstate_norm(wstate_norm), .wstate_oth(wstate_oth), .rd_we(rd_we), .rd_sum(rd_sum),
    .trap_req(trap_req), .trap_kind(trap_kind), .trap_ws(trap_ws)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [2:0] s, input logic [5:0] d);
    wr_go = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_go = 1'b0;
  endtask

  function automatic logic [31:0] obs();
    return {10'd0, cwp, cansave, canrestore, cleanwin, otherwin, trap_req, trap_kind, trap_ws, rd_we};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R10 watchdog expired: actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1: reset values
    check(obs() == {10'd0, 3'd0, 3'd6, 3'd0, 3'd6, 3'd0, 1'b0, 2'b00, 3'd0, 1'b0} &&
          wstate_norm == 0 && wstate_oth == 0, "R1 reset state", obs(),
          {10'd0, 3'd0, 3'd6, 3'd0, 3'd6, 3'd0, 1'b0, 2'b00, 3'd0, 1'b0});
    rst_n = 1'b1;
    @(negedge clk);

    // R9: each privileged write visible next cycle
    put(3'd0, 6'd5); check(cwp == 3'd5, "R9 write cwp", 32'(cwp), 32'd5);
    put(3'd5, 6'o63); check({wstate_oth, wstate_norm} == 6'o63, "R9 write selectors",
                            32'({wstate_oth, wstate_norm}), 32'o63);

    // R9: write wins over same-cycle save
    wr_go = 1'b1; wr_sel = 3'd1; wr_data = 6'd4; op_go = 1'b1; op_sel = 2'b00;
    @(negedge clk);
    wr_go = 1'b0; op_go = 1'b0;
    check(cansave == 3'd4 && cwp == 3'd5 && !trap_req && !rd_we, "R9 write beats op",
          {26'd0, cwp, cansave}, {26'd0, 3'd5, 3'd4});

    // R10: op_sel 11 leaves state alone
    op_go = 1'b1; op_sel = 2'b11;
    @(negedge clk);
    op_go = 1'b0;
    check(cwp == 3'd5 && cansave == 3'd4 && !trap_req && !rd_we, "R10 null op ignored",
          {26'd0, cwp, cansave}, {26'd0, 3'd5, 3'd4});

    // Sweep over the whole eight-window state space
    for (int cs = 0; cs < 8; cs++)
      for (int cr = 0; cr < 8; cr++)
        for (int cl = 0; cl < 8; cl++)
          for (int owi = 0; owi < 2; owi++)
            for (int op = 0; op < 3; op++) begin
              int cw, ow, ecw, ecs, ecr, ek, ews, ewe, wsn, wso;
              logic [15:0] esum;
              logic [31:0] exp;
              string tag;
              cw  = (cs * 3 + cr) % 8;
              ow  = owi * 3;
              wsn = cr;
              wso = cl ^ 5;
              put(3'd0, 6'(cw));
              put(3'd1, 6'(cs));
              put(3'd2, 6'(cr));
              put(3'd3, 6'(cl));
              put(3'd4, 6'(ow));
              put(3'd5, 6'((wso << 3) | wsn));
              a_in = 16'(cs * 4099 + cr * 37);
              b_in = 16'(cl * 911 + ow + op);
              esum = a_in + b_in;
              op_go = 1'b1; op_sel = 2'(op);
              @(negedge clk);
              op_go = 1'b0;
              ecw = cw; ecs = cs; ecr = cr; ek = 0; ewe = 0;
              case (op)
                0: begin
                  if (cs == 0) begin ek = 1; ecw = (cw + 2) % 8; tag = "R2 save spill R7"; end
                  else if (cl == cr) begin ek = 3; ecw = (cw + 1) % 8; tag = "R3 save clean"; end
                  else begin
                    ecw = (cw + 1) % 8; ecs = cs - 1; ecr = (cr == 7) ? 7 : cr + 1; ewe = 1;
                    tag = "R4 save normal";
                  end
                end
                1: begin
                  ecw = (cw + 7) % 8;
                  if (cr == 0) begin ek = 2; tag = "R5 R6 restore fill R7"; end
                  else begin
                    ecs = (cs == 7) ? 7 : cs + 1; ecr = cr - 1; ewe = 1;
                    tag = "R5 R6 restore normal";
                  end
                end
                default: begin
                  if (cs != 6) begin ek = 1; tag = "R8 flush spill R7"; end
                  else tag = "R8 flush quiet";
                end
              endcase
              ews = (ek == 1 || ek == 2) ? ((ow != 0) ? wso : wsn) : 0;
              exp = {10'd0, 3'(ecw), 3'(ecs), 3'(ecr), 3'(cl), 3'(ow), 1'(ek != 0), 2'(ek), 3'(ews), 1'(ewe)};
              check(obs() == exp, tag, obs(), exp);
              if (ewe != 0) check(rd_sum == esum, "R4 R6 destination sum", 32'(rd_sum), 32'(esum));
              @(negedge clk);
              check(!trap_req && !rd_we && trap_kind == 2'b00 && trap_ws == 3'd0, "R10 pulse ends",
                    {26'd0, trap_req, rd_we, trap_kind, 2'b00}, 32'd0);
            end

    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule